// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block guards a processor against runaway software. Software arms it by writing one control word. The word carries a reload count, a run bit and a 7-bit key. Once the watchdog runs, software must keep rewriting the word before the count runs out. While the stored run bit is set, a write is accepted only when its key is the bitwise inverse of the key already stored. A program that has lost its way is therefore unlikely to service the watchdog by accident.

The counter decrements once per pulse of a slow tick-enable input. When it first runs out, the block raises a non-maskable interrupt (NMI) and starts a short grace countdown. If the grace countdown also runs out, the block emits a one-cycle reset request. It then freezes until the external reset arrives.

The behaviour is organised as five named states:
- `ST_STOP`: the counter holds its value.
- `ST_ARMED`: first-stage counting.
- `ST_GRACE`: the NMI is raised and the grace countdown runs.
- `ST_FIRE`: the one-cycle reset request.
- `ST_HALT`: frozen until reset.

The transitions are:
- An accepted write leads from STOP, ARMED or GRACE to ARMED when the new run bit is 1, and to STOP when it is 0.
- A tick that empties the counter in ARMED leads to GRACE.
- A tick that empties the counter in GRACE leads to FIRE.
- FIRE always leads to HALT.
- HALT stays in HALT until reset.

Top module: `wdog_keyed_top`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, and both the NMI and the reset request are low.
- R2: While the stored run bit (bit 8) is 0, any write to the control offset 0x40 is accepted, and the whole 32-bit word reads back from 0x40.
- R3: While the stored run bit is 1, a write is ignored unless bits [15:9] of the write equal the bitwise inverse of the stored bits [15:9]. An ignored write changes neither the control word nor the count.
- R4: An accepted write loads the counter from bits [7:0] of the word, with 0 loading 256. The status word at offset 0x44 shows the count in bits [8:0].
- R5: With run bit 1, the count drops by one per tick-enable pulse. With run bit 0, ticks leave the count unchanged.
- R6: The tick that takes the count from 1 to expiry raises the NMI on the following cycle. The status word then shows the hit flag in bit 9 and a count of 10.
- R7: An accepted write during the grace countdown lowers the NMI, clears the hit flag and reloads the counter.
- R8: The 10th grace tick produces a reset request exactly one cycle wide. Afterwards the NMI stays high, no further request appears, and every write is ignored until reset.
- R9: Reads of any offset other than 0x40 and 0x44 return 0. Writes to such offsets change nothing.
- R10: A write accepted in the same cycle as a tick takes precedence: the count is the newly loaded value, not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Slow count-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| nmi_o | output | 1 | Non-maskable interrupt, level |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is a write that arrives during the grace countdown with the correct key, or with a nearly correct one. Random stimulus rarely produces both an expiry and a matching key at the right moment. The stimulus therefore uses short reload counts and frequent ticks so that expiries happen often. It forms the key from the bench's own copy of the stored key about half the time and picks a random key otherwise. Each time the model reaches the halted state, the bench applies a reset so that the run visits the escalation path many times.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_FLD_W = 8;
    localparam int CNT_W     = CNT_FLD_W + 1;
    localparam int RUN_BIT   = 8;
    localparam int KEY_LSB   = 9;
    localparam int KEY_W     = 7;
    localparam int HIT_BIT   = 9;
    localparam int CTRL_OFF  = 'h40;
    localparam int STAT_OFF  = 'h44;

    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_ARMED = 3'd1,
        ST_GRACE = 3'd2,
        ST_FIRE  = 3'd3,
        ST_HALT  = 3'd4
    } wd_state_e;
endpackage

// File: rtl/wdog_keygate.sv
module wdog_keygate
    import wdog_keyed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel_ctrl,
    input  logic              frozen,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              accept
);
    logic key_ok;

    // A locked watchdog wants the inverse of the key it holds.
    assign key_ok = (wdata[KEY_LSB +: KEY_W] == ~ctrl_q[KEY_LSB +: KEY_W]);
    assign accept = wr_en && sel_ctrl && !frozen && (!ctrl_q[RUN_BIT] || key_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (accept) begin
            ctrl_q <= wdata;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_keyed_pkg::*;
#(
    parameter int GRACE_TICKS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_user,
    input  logic [CNT_FLD_W-1:0] user_field,
    input  logic                 load_grace,
    input  logic                 dec,
    output logic [CNT_W-1:0]     count,
    output logic                 at_one
);
    localparam logic [CNT_W-1:0] FULL_LOAD  = CNT_W'(1) << CNT_FLD_W;
    localparam logic [CNT_W-1:0] GRACE_LOAD = CNT_W'(GRACE_TICKS);

    logic [CNT_W-1:0] user_load;

    assign user_load = (user_field == '0) ? FULL_LOAD : {1'b0, user_field};
    assign at_one    = (count == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_user) begin
            count <= user_load;
        end else if (load_grace) begin
            count <= GRACE_LOAD;
        end else if (dec) begin
            count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_keyed_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  logic      run_req,
    input  logic      tick_en,
    input  logic      at_one,
    output wd_state_e state_q,
    output logic      nmi,
    output logic      rst_req,
    output logic      frozen,
    output logic      load_grace,
    output logic      dec
);
    wd_state_e state_d;
    wd_state_e after_write;

    assign after_write = run_req ? ST_ARMED : ST_STOP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (accept) state_d = after_write;
            end
            ST_ARMED: begin
                if (accept)                  state_d = after_write;
                else if (tick_en && at_one)  state_d = ST_GRACE;
            end
            ST_GRACE: begin
                if (accept)                  state_d = after_write;
                else if (tick_en && at_one)  state_d = ST_FIRE;
            end
            ST_FIRE:  state_d = ST_HALT;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_STOP;
        endcase
    end

    always_comb begin
        nmi        = 1'b0;
        rst_req    = 1'b0;
        frozen     = 1'b0;
        load_grace = 1'b0;
        dec        = 1'b0;
        unique case (state_q)
            ST_STOP: ;
            ST_ARMED: begin
                dec        = tick_en && !accept;
                load_grace = tick_en && at_one && !accept;
            end
            ST_GRACE: begin
                nmi = 1'b1;
                dec = tick_en && !accept;
            end
            ST_FIRE: begin
                nmi     = 1'b1;
                rst_req = 1'b1;
                frozen  = 1'b1;
            end
            ST_HALT: begin
                nmi    = 1'b1;
                frozen = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
    import wdog_keyed_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int GRACE_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              nmi_o,
    output logic              rst_req_o
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept, frozen, at_one, load_grace, dec;
    logic              sel_ctrl;
    wd_state_e         state_q;

    assign sel_ctrl = (addr == CTRL_A);

    wdog_keygate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel_ctrl (sel_ctrl),
        .frozen   (frozen),
        .wdata    (wdata),
        .ctrl_q   (ctrl_q),
        .accept   (accept)
    );

    wdog_counter #(.GRACE_TICKS(GRACE_TICKS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_user  (accept),
        .user_field (wdata[CNT_FLD_W-1:0]),
        .load_grace (load_grace),
        .dec        (dec),
        .count      (cnt_q),
        .at_one     (at_one)
    );

    wdog_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .run_req    (wdata[RUN_BIT]),
        .tick_en    (tick_en),
        .at_one     (at_one),
        .state_q    (state_q),
        .nmi        (nmi_o),
        .rst_req    (rst_req_o),
        .frozen     (frozen),
        .load_grace (load_grace),
        .dec        (dec)
    );

    always_comb begin
        rdata = '0;
        if (addr == CTRL_A) begin
            rdata = ctrl_q;
        end else if (addr == STAT_A) begin
            rdata[CNT_W-1:0] = cnt_q;
            rdata[HIT_BIT]   = nmi_o;
        end
    end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
    import wdog_keyed_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              nmi_o,
    input logic              rst_req_o,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]  cnt_q,
    input wd_state_e         state_q
);
    AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(CTRL_OFF) && ctrl_q[RUN_BIT] &&
         wdata[KEY_LSB +: KEY_W] != ~ctrl_q[KEY_LSB +: KEY_W]) |=> $stable(ctrl_q)); // R3
    AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (cnt_q != '0)); // R4
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !wr_en) |=> $stable(cnt_q)); // R5
    AST_NMI_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(tick_en)); // R6
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R8
    AST_REQ_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(nmi_o)); // R8
    AST_NMI_HELD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> nmi_o); // R8
endmodule

bind wdog_keyed_top wdog_keyed_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o),
    .ctrl_q    (ctrl_q),
    .cnt_q     (cnt_q),
    .state_q   (state_q)
);

// File: tb/wdog_keyed_top_tb_top.sv
module wdog_keyed_top_tb_top;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_STAT = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        nmi_o, rst_req_o;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model: 0 stop, 1 armed, 2 grace, 3 fire, 4 halt
    int          m_state = 0;
    logic [31:0] m_ctrl = 32'h0;
    int          m_cnt = 0;

    always #10 clk = ~clk;

    wdog_keyed_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .nmi_o(nmi_o), .rst_req_o(rst_req_o)
    );

    function automatic logic [31:0] mk(input logic [6:0] key, input logic run, input logic [7:0] cnt);
        return {16'h0, key, run, cnt};
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == A_CTRL) return m_ctrl;
        if (a == A_STAT) return ((m_state >= 2) ? 32'h200 : 32'h0) | 32'(m_cnt);
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input bit w, input logic [7:0] a, input logic [31:0] d, input bit t);
        bit acc;
        acc = w && a == A_CTRL && m_state < 3 &&
              (!m_ctrl[8] || d[15:9] == ~m_ctrl[15:9]);
        if (m_state == 3) m_state = 4;
        else if (m_state == 4) m_state = 4;
        else if (acc) begin
            m_ctrl  = d;
            m_cnt   = (d[7:0] == 8'h0) ? 256 : int'(d[7:0]);
            m_state = d[8] ? 1 : 0;
        end else if (t && m_state == 1) begin
            if (m_cnt == 1) begin m_state = 2; m_cnt = 10; end
            else m_cnt--;
        end else if (t && m_state == 2) begin
            m_cnt--;
            if (m_cnt == 0) m_state = 3;
        end
    endtask

    task automatic cycle(input bit w, input logic [7:0] a, input logic [31:0] d, input bit t, input string tag);
        wr_en = w; addr = a; wdata = d; tick_en = t;
        @(posedge clk);
        model_step(w, a, d, t);
        @(negedge clk);
        chk(tag, "rdata", rdata, exp_read(a));
        chk(tag, "nmi", 32'(nmi_o), 32'(m_state >= 2));
        chk(tag, "rst_req", 32'(rst_req_o), 32'(m_state == 3));
    endtask

    task automatic do_reset();
        wr_en = 0; tick_en = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        m_state = 0; m_ctrl = 0; m_cnt = 0;
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [6:0] k;
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();
        // R1 reset state
        cycle(0, A_CTRL, 0, 0, "R1");
        cycle(0, A_STAT, 0, 0, "R1");
        // R2 unlocked write with arbitrary key, R5 ticks ignored when stopped
        cycle(1, A_CTRL, 32'hABCD_0000 | mk(7'h33, 0, 3), 0, "R2");
        cycle(0, A_STAT, 0, 1, "R5");
        // R4 zero count means 256
        k = 7'h15;
        cycle(1, A_CTRL, mk(k, 1, 0), 0, "R4");
        cycle(0, A_STAT, 0, 0, "R4");
        cycle(0, A_STAT, 0, 1, "R5");
        // R3 locked: same key (not inverse) is ignored
        cycle(1, A_CTRL, mk(k, 1, 5), 0, "R3");
        cycle(0, A_STAT, 0, 0, "R3");
        cycle(1, A_CTRL, mk(7'h00, 0, 5), 0, "R3");
        // R6 expiry raises NMI with grace count
        cycle(1, A_CTRL, mk(~k, 1, 2), 0, "R6");
        cycle(0, A_STAT, 0, 1, "R6");
        cycle(0, A_STAT, 0, 1, "R6");
        // R7 accepted write in grace clears NMI
        cycle(1, A_CTRL, mk(k, 1, 1), 0, "R7");
        cycle(0, A_STAT, 0, 0, "R7");
        // R8 escalation to reset request
        cycle(0, A_STAT, 0, 1, "R6");
        for (int i = 0; i < 10; i++) cycle(0, A_STAT, 0, 1, "R8");
        cycle(0, A_STAT, 0, 1, "R8");
        cycle(1, A_CTRL, mk(~k, 0, 4), 1, "R8");
        cycle(0, A_STAT, 0, 0, "R8");
        // R9 unmapped offsets
        do_reset();
        cycle(1, 8'h48, 32'h0000_FFFF, 0, "R9");
        cycle(0, A_CTRL, 0, 0, "R9");
        cycle(0, A_STAT, 0, 0, "R9");
        // R10 write beats tick
        cycle(1, A_CTRL, mk(7'h01, 1, 4), 0, "R10");
        cycle(0, A_STAT, 0, 1, "R10");
        cycle(1, A_CTRL, mk(7'h7E, 1, 9), 1, "R10");
        cycle(0, A_STAT, 0, 0, "R10");
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            bit          w, t;
            int          sel;
            if (m_state == 4 && ($urandom % 4) == 0) begin
                do_reset();
                cycle(0, A_STAT, 0, 0, "R1");
            end
            sel = $urandom % 10;
            a = (sel < 5) ? A_STAT : (sel < 9) ? A_CTRL : 8'($urandom);
            w = ($urandom % 6) == 0;
            t = ($urandom % 2) == 0;
            k = (($urandom % 2) == 0) ? ~m_ctrl[15:9] : 7'($urandom);
            d = {16'($urandom), k, 1'($urandom % 4 != 0), 8'($urandom % 7)};
            cycle(w, a, d, t, "R5");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule